// File: doc/BRIEF.md
# Bypassing Array Multiplier with Lookahead Merge Stage

This block multiplies two unsigned operands of `WIDTH` bits and gives the full `2*WIDTH`-bit product. The operands are held in input registers that load on any clock edge where `load` is high. The product and a line-activity count are formed combinationally from those registers. The partial products are summed in an array of adder lines. One operand is the control operand, and each of its bits, except bit 0, owns one adder line. When a control bit is zero, its line does no work. The line's adder inputs are forced low by AND gating, so those adders see no switching. The line's outputs pass on the running sum unchanged, and all of its carries are held at zero.

The last line does not use a ripple adder. It uses a carry-lookahead adder made of 4-bit groups. Inside each group, the carries are written out as flat two-level sum-of-products terms. Between groups, the carry ripples.

The parameter `MODE` picks which operand is the control operand. In row mode the control operand is `op_b` (the multiplier), so whole rows are skipped. In column mode the control operand is `op_a` (the multiplicand). The output `active_lines` reports how many lines are doing real work for the operands currently held.

Top module: `bypass_array_mult`

## Requirements
- R1: While `rst_n` is low, both operand registers are held at zero. During that time `product` reads 0 and `active_lines` reads 0, whatever `load`, `op_a` and `op_b` do.
- R2: The operand registers load on a rising clock edge where `load` is 1. The outputs show the new operands after that edge. On an edge where `load` is 0, `product` and `active_lines` keep their values, even if `op_a` and `op_b` change.
- R3: In row mode (`MODE` = LINE_ROW, control operand = `op_b`), `product` equals the unsigned product of the loaded `op_a` and `op_b` for every operand pair.
- R4: In column mode (`MODE` = LINE_COL, control operand = `op_a`), `product` equals the unsigned product of the loaded `op_a` and `op_b` for every operand pair.
- R5: `active_lines` equals the number of ones in bits `WIDTH-1` down to 1 of the loaded control operand. Bit 0 is never counted.
- R6: A line whose control bit is 0 leaves the running sum unchanged. In a 4-bit row-mode instance, `op_a`=4'b1111 with `op_b`=4'b1001 gives `product`=135 and `active_lines`=1. A control operand of zero gives `product`=0 and `active_lines`=0.
- R7: When both operands are all ones, the carry runs through every lookahead group. `product` equals (2^WIDTH-1)^2 and `active_lines` equals `WIDTH-1`.
- R8: With `WIDTH`=16, the last line is built from four lookahead groups with ripple between them. `product` still equals the exact unsigned product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the operand registers |
| rst_n | input | 1 | Active-low synchronous reset of the operand registers |
| load | input | 1 | When high, the operand registers take `op_a` and `op_b` on this edge |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| product | output | 2*WIDTH | Unsigned product of the registered operands |
| active_lines | output | $clog2(WIDTH) | Number of adder lines in use for the registered operands |

## Verification
The checker assumes that `load`, `op_a` and `op_b` are settled and free of X before each rising edge. It also assumes that a result is only judged one edge after it was loaded, since the checker compares the outputs with the operands from the previous cycle.

The bench changes inputs only at falling edges and reads outputs at the next falling edge. This keeps every captured value stable around the edge where it is taken. The 4-bit instances are swept over all operand pairs. The 16-bit instance receives pseudo-random pairs together with the all-ones corner case.

// File: rtl/bypass_array_mult_pkg.sv
package bypass_array_mult_pkg;
   typedef enum logic {
      LINE_ROW = 1'b0,
      LINE_COL = 1'b1
   } line_mode_e;

   function automatic int unsigned lookahead_groups(int unsigned w);
      return (w + 3) / 4;
   endfunction
endpackage

// File: rtl/bam_fa_cell.sv
module bam_fa_cell (
   input  logic pass_en,
   input  logic pp_src,
   input  logic sum_in,
   input  logic carry_in,
   output logic sum_out,
   output logic carry_out
);
   logic x_g, y_g, z_g, s_raw, c_raw;

   // operand isolation: an idle line sees constant zeros
   assign x_g = pp_src   & pass_en;
   assign y_g = sum_in   & pass_en;
   assign z_g = carry_in & pass_en;

   assign s_raw = x_g ^ y_g ^ z_g;
   assign c_raw = (x_g & y_g) | (z_g & (x_g ^ y_g));

   assign sum_out   = pass_en ? s_raw : sum_in;
   assign carry_out = pass_en ? c_raw : 1'b0;
endmodule

// File: rtl/bam_row.sv
module bam_row #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             line_en,
   input  logic [WIDTH-1:0] acc_in,
   input  logic [WIDTH-1:0] other_op,
   output logic [WIDTH:0]   acc_out
);
   logic [WIDTH:0]   chain;
   logic [WIDTH-1:0] sums;

   assign chain[0] = 1'b0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      bam_fa_cell u_cell (
         .pass_en  (line_en),
         .pp_src   (other_op[i]),
         .sum_in   (acc_in[i]),
         .carry_in (chain[i]),
         .sum_out  (sums[i]),
         .carry_out(chain[i+1])
      );
   end

   assign acc_out = {chain[WIDTH], sums};
endmodule

// File: rtl/bam_cla_adder.sv
module bam_cla_adder #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   output logic [WIDTH:0]   total
);
   import bypass_array_mult_pkg::*;

   localparam int unsigned NGRP = lookahead_groups(WIDTH);
   localparam int unsigned PADW = NGRP * 4;

   logic [PADW-1:0] xp, yp, spad;
   logic [NGRP:0]   gcar;
   logic [PADW:0]   full;

   assign xp      = PADW'(x);
   assign yp      = PADW'(y);
   assign gcar[0] = 1'b0;

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic [3:0] pr, gn;
      logic [4:0] c;
      // level 1: propagate / generate
      assign pr = xp[4*g +: 4] ^ yp[4*g +: 4];
      assign gn = xp[4*g +: 4] & yp[4*g +: 4];
      // level 2: flattened two-level carry terms
      assign c[0] = gcar[g];
      assign c[1] = gn[0] | (pr[0] & c[0]);
      assign c[2] = gn[1] | (pr[1] & gn[0]) | (pr[1] & pr[0] & c[0]);
      assign c[3] = gn[2] | (pr[2] & gn[1]) | (pr[2] & pr[1] & gn[0])
                  | (pr[2] & pr[1] & pr[0] & c[0]);
      assign c[4] = gn[3] | (pr[3] & gn[2]) | (pr[3] & pr[2] & gn[1])
                  | (pr[3] & pr[2] & pr[1] & gn[0])
                  | (pr[3] & pr[2] & pr[1] & pr[0] & c[0]);
      // level 3: sum bits
      assign spad[4*g +: 4] = pr ^ c[3:0];
      assign gcar[g+1]      = c[4];
   end

   assign full  = {gcar[NGRP], spad};
   assign total = full[WIDTH:0];
endmodule

// File: rtl/bam_array.sv
module bam_array #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0]   ctrl_op,
   input  logic [WIDTH-1:0]   other_op,
   output logic [2*WIDTH-1:0] prod
);
   logic [WIDTH-1:0] pp0;
   logic [WIDTH-1:0] hi [0:WIDTH-2];

   assign pp0     = other_op & {WIDTH{ctrl_op[0]}};
   assign prod[0] = pp0[0];
   assign hi[0]   = {1'b0, pp0[WIDTH-1:1]};

   for (genvar j = 1; j <= WIDTH - 2; j++) begin : g_line
      logic [WIDTH:0] lo;
      bam_row #(.WIDTH(WIDTH)) u_row (
         .line_en (ctrl_op[j]),
         .acc_in  (hi[j-1]),
         .other_op(other_op),
         .acc_out (lo)
      );
      assign prod[j] = lo[0];
      assign hi[j]   = lo[WIDTH:1];
   end

   // final line: lookahead merge with the same gating and bypass
   logic             last_en;
   logic [WIDTH-1:0] fx, fy;
   logic [WIDTH:0]   fsum;

   assign last_en = ctrl_op[WIDTH-1];
   assign fx      = hi[WIDTH-2] & {WIDTH{last_en}};
   assign fy      = other_op    & {WIDTH{last_en}};

   bam_cla_adder #(.WIDTH(WIDTH)) u_merge (
      .x    (fx),
      .y    (fy),
      .total(fsum)
   );

   assign prod[2*WIDTH-1:WIDTH-1] = last_en ? fsum : {1'b0, hi[WIDTH-2]};
endmodule

// File: rtl/bypass_array_mult.sv
module bypass_array_mult #(
   parameter int unsigned                        WIDTH = 4,
   parameter bypass_array_mult_pkg::line_mode_e  MODE  = bypass_array_mult_pkg::LINE_ROW
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load,
   input  logic [WIDTH-1:0]           op_a,
   input  logic [WIDTH-1:0]           op_b,
   output logic [2*WIDTH-1:0]         product,
   output logic [$clog2(WIDTH)-1:0]   active_lines
);
   import bypass_array_mult_pkg::*;

   localparam int unsigned CNT_W = $clog2(WIDTH);

   if (WIDTH < 2) begin : g_bad_width
      $error("bypass_array_mult: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] a_q, b_q, ctrl_q, other_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (load) begin
         a_q <= op_a;
         b_q <= op_b;
      end
   end

   if (MODE == LINE_ROW) begin : g_row_mode
      assign ctrl_q  = b_q;
      assign other_q = a_q;
   end else begin : g_col_mode
      assign ctrl_q  = a_q;
      assign other_q = b_q;
   end

   bam_array #(.WIDTH(WIDTH)) u_array (
      .ctrl_op (ctrl_q),
      .other_op(other_q),
      .prod    (product)
   );

   always_comb begin
      active_lines = '0;
      for (int i = 1; i < int'(WIDTH); i++) begin
         active_lines = active_lines + CNT_W'(ctrl_q[i]);
      end
   end
endmodule

// File: rtl/bypass_array_mult_chk.sv
module bypass_array_mult_chk #(
   parameter int unsigned                        WIDTH = 4,
   parameter bypass_array_mult_pkg::line_mode_e  MODE  = bypass_array_mult_pkg::LINE_ROW
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     load,
   input logic [WIDTH-1:0]         op_a,
   input logic [WIDTH-1:0]         op_b,
   input logic [2*WIDTH-1:0]       product,
   input logic [$clog2(WIDTH)-1:0] active_lines
);
   import bypass_array_mult_pkg::*;

   logic [WIDTH-1:0]   ctrl_in;
   logic [2*WIDTH-1:0] wa, wb;

   assign ctrl_in = (MODE == LINE_ROW) ? op_b : op_a;
   assign wa      = (2*WIDTH)'(op_a);
   assign wb      = (2*WIDTH)'(op_b);

   // R2: no load, no change at the outputs
   assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(product) && $stable(active_lines)));

   // R3 in row mode, R4 in column mode
   assert_exact_product_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (product == ($past(wa) * $past(wb))));

   assert_line_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (32'(active_lines) == 32'($countones($past(ctrl_in) >> 1))));

   assert_zero_control_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (ctrl_in == '0)) |=> ((product == '0) && (active_lines == '0)));
endmodule

bind bypass_array_mult bypass_array_mult_chk #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .load        (load),
   .op_a        (op_a),
   .op_b        (op_b),
   .product     (product),
   .active_lines(active_lines)
);

// File: tb/tb_bypass_array_mult.sv
module tb_bypass_array_mult;
   import bypass_array_mult_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [3:0]  a4 = '0, b4 = '0;
   logic [15:0] a16 = '0, b16 = '0;
   logic [7:0]  p_row, p_col;
   logic [1:0]  n_row, n_col;
   logic [31:0] p_wide;
   logic [3:0]  n_wide;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bypass_array_mult #(.WIDTH(4), .MODE(LINE_ROW)) dut (
      .clk(clk), .rst_n(rst_n), .load(load), .op_a(a4), .op_b(b4),
      .product(p_row), .active_lines(n_row));

   bypass_array_mult #(.WIDTH(4), .MODE(LINE_COL)) dut_col (
      .clk(clk), .rst_n(rst_n), .load(load), .op_a(a4), .op_b(b4),
      .product(p_col), .active_lines(n_col));

   bypass_array_mult #(.WIDTH(16), .MODE(LINE_ROW)) dut_wide (
      .clk(clk), .rst_n(rst_n), .load(load), .op_a(a16), .op_b(b16),
      .product(p_wide), .active_lines(n_wide));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset holds everything at zero even with load high
      a4 = 4'hF; b4 = 4'hF; a16 = 16'hFFFF; b16 = 16'hFFFF; load = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 row product", 64'(p_row), 0);
      check("R1 row count", 64'(n_row), 0);
      check("R1 col product", 64'(p_col), 0);
      check("R1 wide product", 64'(p_wide), 0);
      check("R1 wide count", 64'(n_wide), 0);
      rst_n = 1'b1;
      load  = 1'b0;
      @(negedge clk);

      // R3 R4 R5: exhaustive sweep of the 4-bit instances, random wide pairs (R8)
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            a4 = 4'(a); b4 = 4'(b);
            a16 = 16'($urandom); b16 = 16'($urandom);
            load = 1'b1;
            @(negedge clk);
            check("R3", 64'(p_row), 64'(a * b));
            check("R4", 64'(p_col), 64'(a * b));
            check("R5 row", 64'(n_row), 64'($countones(b4[3:1])));
            check("R5 col", 64'(n_col), 64'($countones(a4[3:1])));
            check("R8", 64'(p_wide), 64'(a16) * 64'(b16));
            check("R5 wide", 64'(n_wide), 64'($countones(b16[15:1])));
         end
      end

      // R6: example pattern, rows 1 and 2 idle
      a4 = 4'b1111; b4 = 4'b1001; load = 1'b1;
      @(negedge clk);
      check("R6 product", 64'(p_row), 135);
      check("R6 count", 64'(n_row), 1);
      // R6: zero control operand
      a4 = 4'b1011; b4 = 4'b0000; a16 = 16'hBEEF; b16 = 16'h0000;
      @(negedge clk);
      check("R6 zero product", 64'(p_row), 0);
      check("R6 zero count", 64'(n_row), 0);
      check("R6 zero wide", 64'(p_wide), 0);
      check("R6 col count", 64'(n_col), 64'($countones(a4[3:1])));

      // R7: all ones through every lookahead group
      a4 = 4'hF; b4 = 4'hF; a16 = 16'hFFFF; b16 = 16'hFFFF;
      @(negedge clk);
      check("R7 row", 64'(p_row), 225);
      check("R7 col", 64'(p_col), 225);
      check("R7 count", 64'(n_row), 3);
      check("R7 wide", 64'(p_wide), 64'(32'hFFFE_0001));
      check("R7 wide count", 64'(n_wide), 15);

      // R2: load low, inputs change, outputs hold
      a4 = 4'd6; b4 = 4'd7; a16 = 16'd300; b16 = 16'd5;
      @(negedge clk);
      load = 1'b0;
      a4 = 4'd9; b4 = 4'd2; a16 = 16'd1; b16 = 16'd1;
      @(negedge clk);
      @(negedge clk);
      check("R2 hold row", 64'(p_row), 42);
      check("R2 hold count", 64'(n_row), 2);
      check("R2 hold col", 64'(p_col), 42);
      check("R2 hold wide", 64'(p_wide), 1500);
      load = 1'b1;
      @(negedge clk);
      check("R2 reload row", 64'(p_row), 18);
      check("R2 reload wide", 64'(p_wide), 1);
      load = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule